// File: doc/BRIEF.md
# Channel List Sequencer with Pacer

This block steps an analog front end through a programmed list of channel, gain and input-mode settings. The host fills the list one 16-bit entry at a time, sending each entry as two byte writes to a single address. The host also loads a 24-bit pacer divisor and picks which of four base clock enables the pacer counts. An arm command starts a run. A stop command ends it. A reset-queue command empties the list.

The current entry appears on a valid/ready output toward the converter. A transfer (`conv_valid` and `conv_ready` high at a rising edge) is one finished conversion. The converter may hold `conv_ready` low for as long as it needs. While it does, `conv_valid` stays high and the presented fields do not change.

Each entry has a start flag, which sets its timing:
- An entry with the flag set waits for a pacer tick before it is presented.
- An entry without the flag is presented in the cycle after the previous transfer.

Setting the flag on every entry gives one conversion per pacer period. Setting it only on the first entry gives one burst scan per period.

The block has two modes. In one-shot mode each arm performs a single conversion. In continuous mode the block cycles through the list, wrapping back to the first entry, until it is stopped.

Top module: `chanlist_sequencer`

## Requirements
- R1: Entry format. An entry is written as a low byte and then a high byte, both to address 0. Low byte bit 7 is the start flag. High byte bit 6 is the differential select, bits 5:4 are the gain and bits 3:0 are the channel. These appear on `conv_diff`, `conv_gain` and `conv_chan` when the entry is presented.
- R2: Start flag timing. An entry whose start flag is set is presented only after a pacer tick. An entry whose start flag is clear is presented in the cycle after the previous transfer.
- R3: Pacer divisor. The divisor is written at addresses 3, 4 and 5 (low, middle, high byte). Arm clears the pacer count. A waiting entry is presented D selected-enable cycles after the arm edge, where D is the divisor. A divisor of 0 behaves as 1. The counter reloads on each tick.
- R4: Clock select. Control register (address 1) bits 1:0 select which `base_en` bit the pacer counts: 0 external, 1 5 MHz, 2 1 MHz, 3 100 kHz. Enables on the unselected bits have no effect.
- R5: One-shot mode. With control bit 2 = 0, each arm performs exactly one conversion. `running` then falls in the cycle after that transfer. `running` is low after reset.
- R6: Continuous mode. With control bit 2 = 1, conversions follow the list in order, wrap from the last entry back to entry 0, and continue until stopped.
- R7: Completion pulses. `conv_done` pulses for one cycle after each transfer. `scan_end` pulses together with it when the transferred entry was the last one in the list.
- R8: Stop. Command bit 1 at address 2 ends any run. After that edge `running` and `conv_valid` are low.
- R9: Reset queue. Command bit 2 empties the list, returns reading to entry 0, discards any half-written entry and ends any run.
- R10: Full list. Once DEPTH entries are stored, further entry writes are ignored.
- R11: Back-pressure. While `conv_valid` is high and `conv_ready` is low, the presentation and its fields hold unless a stop or reset-queue command arrives.
- R12: Empty list. Arm with an empty list is ignored and `running` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | 3 | 0 entry, 1 control, 2 command, 3..5 pacer bytes |
| wr_data | input | 8 | Host write byte |
| base_en | input | 4 | Base clock enable pulses, indexed by clock select |
| conv_valid | output | 1 | Entry presented to the converter |
| conv_ready | input | 1 | Converter accepts (conversion ends) |
| conv_chan | output | 4 | Channel of the presented entry |
| conv_gain | output | 2 | Gain of the presented entry |
| conv_diff | output | 1 | Differential select of the presented entry |
| conv_done | output | 1 | One-cycle pulse after each transfer |
| scan_end | output | 1 | One-cycle pulse after the last entry of a pass |
| running | output | 1 | High from arm until the run ends |

## Verification
A wrong read pointer or a missed wrap shows at the next transfer as wrong channel or gain fields, so the scoreboard catches it one conversion later. A pacer that counts from the wrong value, or counts the wrong enable, moves the edge where `conv_valid` rises relative to arm or to the previous scan start. The bench therefore measures that distance in cycles. A stale run state shows as `running` or `conv_valid` still high in the cycle after a stop, a one-shot transfer, or an arm on an empty list.

// File: rtl/chanseq_pkg.sv
package chanseq_pkg;
  typedef struct packed {
    logic       diff;
    logic [1:0] gain;
    logic [3:0] chan;
    logic       start;
  } entry_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} seq_st_e;

  localparam logic [2:0] ADDR_ENTRY = 3'd0;
  localparam logic [2:0] ADDR_CTRL  = 3'd1;
  localparam logic [2:0] ADDR_CMD   = 3'd2;
  localparam logic [2:0] ADDR_PACER = 3'd3;

  localparam int CMD_ARM  = 0;
  localparam int CMD_STOP = 1;
  localparam int CMD_RSTQ = 2;
  localparam int CTRL_CONT = 2;
endpackage

// File: rtl/chanseq_store.sv
module chanseq_store
  import chanseq_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_byte,
  input  logic                         byte_msb,
  input  logic [6:0]                   byte_low7,
  input  logic                         clear,
  input  logic                         advance,
  output logic [$clog2(DEPTH+1)-1:0]   len,
  output entry_t                       cur,
  output logic                         nxt_start,
  output logic                         at_last
);
  localparam int IW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  entry_t          mem [DEPTH];
  logic            phase_hi;
  logic            lo_start;
  logic [IW-1:0]   rd_ptr;
  logic [IW-1:0]   nxt_ptr;
  logic            full;
  logic            commit;

  assign full    = (len == LW'(DEPTH));
  assign commit  = wr_byte && phase_hi && !full && !clear;
  assign at_last = (LW'(rd_ptr) == len - LW'(1));
  assign nxt_ptr = at_last ? '0 : rd_ptr + IW'(1);
  assign cur       = mem[rd_ptr];
  assign nxt_start = mem[nxt_ptr].start;

  always_ff @(posedge clk) begin
    if (commit)
      mem[len[IW-1:0]] <= '{diff: byte_low7[6], gain: byte_low7[5:4],
                            chan: byte_low7[3:0], start: lo_start};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      phase_hi <= 1'b0;
      lo_start <= 1'b0;
      len      <= '0;
      rd_ptr   <= '0;
    end else begin
      if (wr_byte) begin
        phase_hi <= !phase_hi;
        if (!phase_hi) lo_start <= byte_msb;
      end
      if (commit) len <= len + LW'(1);
      if (advance) rd_ptr <= nxt_ptr;
    end
  end
endmodule

// File: rtl/chanseq_pacer.sv
module chanseq_pacer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   base_en,
  input  logic [1:0]   sel,
  input  logic [W-1:0] divisor,
  input  logic         run,
  input  logic         clear,
  input  logic         consume,
  output logic         tick_avail
);
  logic [W-1:0] cnt;
  logic [W-1:0] lim;
  logic         en;
  logic         tick;
  logic         pend;

  assign en   = base_en[sel];
  assign lim  = (divisor == '0) ? W'(1) : divisor;
  assign tick = run && en && (cnt >= lim - W'(1));
  assign tick_avail = pend || tick;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (run && en) cnt <= tick ? '0 : cnt + W'(1);
      if (consume)   pend <= 1'b0;
      else if (tick) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/chanseq_fsm.sv
module chanseq_fsm
  import chanseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic halt,
  input  logic cont,
  input  logic list_nz,
  input  logic cur_start,
  input  logic nxt_start,
  input  logic at_last,
  input  logic tick_avail,
  input  logic conv_ready,
  output logic conv_valid,
  output logic running,
  output logic arm_go,
  output logic consume,
  output logic advance,
  output logic done_p,
  output logic eos_p
);
  seq_st_e st, st_nx;
  logic    accept;

  assign conv_valid = (st == ST_SEND);
  assign running    = (st != ST_IDLE);
  assign arm_go     = arm && !halt && (st == ST_IDLE) && list_nz;
  assign consume    = (st == ST_WAIT) && tick_avail && !halt;
  assign accept     = (st == ST_SEND) && conv_ready;
  assign advance    = accept;

  always_comb begin
    st_nx = st;
    if (halt) st_nx = ST_IDLE;
    else begin
      unique case (st)
        ST_IDLE: if (arm_go) st_nx = cur_start ? ST_WAIT : ST_SEND;
        ST_WAIT: if (consume) st_nx = ST_SEND;
        ST_SEND: if (accept)
                   st_nx = !cont ? ST_IDLE : (nxt_start ? ST_WAIT : ST_SEND);
        default: st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      done_p <= 1'b0;
      eos_p  <= 1'b0;
    end else begin
      st     <= st_nx;
      done_p <= accept;
      eos_p  <= accept && at_last;
    end
  end
endmodule

// File: rtl/chanlist_sequencer.sv
module chanlist_sequencer
  import chanseq_pkg::*;
#(
  parameter int DEPTH   = 2048,
  parameter int PACER_W = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [3:0] base_en,
  output logic       conv_valid,
  input  logic       conv_ready,
  output logic [3:0] conv_chan,
  output logic [1:0] conv_gain,
  output logic       conv_diff,
  output logic       conv_done,
  output logic       scan_end,
  output logic       running
);
  localparam int LW     = $clog2(DEPTH + 1);
  localparam int NBYTES = PACER_W / 8;

  logic [2:0]         ctrl_q;
  logic [PACER_W-1:0] div_q;
  logic               is_cmd, arm_cmd, halt;
  logic               ent_wr;
  logic [LW-1:0]      len;
  logic               list_empty;
  entry_t             cur;
  logic               nxt_start, at_last;
  logic               arm_go, consume, advance, tick_avail;

  assign is_cmd     = wr_en && (wr_addr == ADDR_CMD);
  assign arm_cmd    = is_cmd && wr_data[CMD_ARM];
  assign halt       = is_cmd && (wr_data[CMD_STOP] || wr_data[CMD_RSTQ]);
  assign ent_wr     = wr_en && (wr_addr == ADDR_ENTRY);
  assign list_empty = (len == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en && wr_addr == ADDR_CTRL) ctrl_q <= wr_data[2:0];
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_div_byte
    always_ff @(posedge clk) begin
      if (!rst_n) div_q[8*b +: 8] <= '0;
      else if (wr_en && wr_addr == ADDR_PACER + 3'(b))
        div_q[8*b +: 8] <= wr_data;
    end
  end

  chanseq_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_byte   (ent_wr),
    .byte_msb  (wr_data[7]),
    .byte_low7 (wr_data[6:0]),
    .clear     (is_cmd && wr_data[CMD_RSTQ]),
    .advance   (advance),
    .len       (len),
    .cur       (cur),
    .nxt_start (nxt_start),
    .at_last   (at_last)
  );

  chanseq_pacer #(.W(PACER_W)) u_pacer (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_en    (base_en),
    .sel        (ctrl_q[1:0]),
    .divisor    (div_q),
    .run        (running),
    .clear      (arm_go || halt),
    .consume    (consume),
    .tick_avail (tick_avail)
  );

  chanseq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm_cmd),
    .halt       (halt),
    .cont       (ctrl_q[CTRL_CONT]),
    .list_nz    (!list_empty),
    .cur_start  (cur.start),
    .nxt_start  (nxt_start),
    .at_last    (at_last),
    .tick_avail (tick_avail),
    .conv_ready (conv_ready),
    .conv_valid (conv_valid),
    .running    (running),
    .arm_go     (arm_go),
    .consume    (consume),
    .advance    (advance),
    .done_p     (conv_done),
    .eos_p      (scan_end)
  );

  assign conv_chan = cur.chan;
  assign conv_gain = cur.gain;
  assign conv_diff = cur.diff;
endmodule

// File: rtl/chanlist_sequencer_chk.sv
module chanlist_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [2:0] cmd_bits,
  input logic       conv_valid,
  input logic       conv_ready,
  input logic [3:0] conv_chan,
  input logic [1:0] conv_gain,
  input logic       conv_diff,
  input logic       conv_done,
  input logic       scan_end,
  input logic       running,
  input logic       list_empty
);
  logic cmd_w, halt_w, arm_w;
  assign cmd_w  = wr_en && (wr_addr == 3'd2);
  assign halt_w = cmd_w && (cmd_bits[1] || cmd_bits[2]);
  assign arm_w  = cmd_w && cmd_bits[0];

  // R11
  hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && !conv_ready && !halt_w) |=>
      (conv_valid && $stable(conv_chan) && $stable(conv_gain) && $stable(conv_diff)));

  // R8
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_w |=> (!running && !conv_valid));

  // R5
  valid_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |-> running);

  // R7
  eos_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_end |-> conv_done);

  // R7
  done_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> $past(conv_valid && conv_ready));

  // R12
  empty_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_w && list_empty && !running) |=> !running);
endmodule

bind chanlist_sequencer chanlist_sequencer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .cmd_bits   (wr_data[2:0]),
  .conv_valid (conv_valid),
  .conv_ready (conv_ready),
  .conv_chan  (conv_chan),
  .conv_gain  (conv_gain),
  .conv_diff  (conv_diff),
  .conv_done  (conv_done),
  .scan_end   (scan_end),
  .running    (running),
  .list_empty (list_empty)
);

// File: tb/chanlist_sequencer_tb.sv
module chanlist_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] base_en = 4'b1111;
  logic       conv_ready = 1'b1;
  logic       conv_valid, conv_diff, conv_done, scan_end, running;
  logic [3:0] conv_chan;
  logic [1:0] conv_gain;

  chanlist_sequencer #(.DEPTH(DEPTH), .PACER_W(24)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .base_en(base_en), .conv_valid(conv_valid), .conv_ready(conv_ready),
    .conv_chan(conv_chan), .conv_gain(conv_gain), .conv_diff(conv_diff),
    .conv_done(conv_done), .scan_end(scan_end), .running(running)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0, hs_cnt = 0, eos_cnt = 0, done_cnt = 0, cyc = 0;
  logic [6:0] exp_q[$];
  int hs_cyc[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_done) done_cnt++;
      if (scan_end) eos_cnt++;
      if (conv_valid && conv_ready) begin
        logic [6:0] act, e;
        act = {conv_diff, conv_gain, conv_chan};
        hs_cnt++;
        hs_cyc.push_back(cyc);
        if (exp_q.size() == 0) check(0, "R6", "unexpected conversion", int'(act), -1);
        else begin
          e = exp_q.pop_front();
          check(act == e, "R1", "entry fields", int'(act), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R5", "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put_entry(input bit st, input bit df, input logic [1:0] g, input logic [3:0] ch);
    wr(3'd0, {st, 7'd0});
    wr(3'd0, {1'b0, df, g, ch});
  endtask

  task automatic push(input bit df, input logic [1:0] g, input logic [3:0] ch);
    exp_q.push_back({df, g, ch});
  endtask

  task automatic set_div(input int d);
    wr(3'd3, d[7:0]); wr(3'd4, d[15:8]); wr(3'd5, d[23:16]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm_measure(output int n);
    wr(3'd2, 8'h01);
    n = 0;
    while (!conv_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n, base, e0, d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(!running && !conv_valid && !conv_done && !scan_end, "R5", "reset outputs idle",
          {running, conv_valid, conv_done, scan_end}, 0);

    // R12: arm with empty list
    wr(3'd2, 8'h01); idle(4);
    check(!running, "R12", "empty arm ignored", running, 0);

    // R1 / R5 / R7: one-shot through three entries and wrap
    wr(3'd1, 8'h01);
    put_entry(0, 0, 2'd1, 4'd3);
    put_entry(0, 1, 2'd2, 4'd9);
    put_entry(0, 1, 2'd3, 4'd15);
    push(0, 1, 3); push(1, 2, 9); push(1, 3, 15); push(0, 1, 3);
    e0 = eos_cnt; d0 = done_cnt; base = hs_cnt;
    for (int k = 0; k < 4; k++) begin
      wr(3'd2, 8'h01); idle(4);
      check(!running, "R5", "one-shot ends run", running, 0);
    end
    check(hs_cnt - base == 4, "R5", "one conversion per arm", hs_cnt - base, 4);
    check(eos_cnt - e0 == 1, "R7", "end-of-scan count", eos_cnt - e0, 1);
    check(done_cnt - d0 == 4, "R7", "done pulse count", done_cnt - d0, 4);

    // R3: pacer delay after arm, divisor 5 then 0
    wr(3'd2, 8'h04);
    put_entry(1, 0, 2'd0, 4'd1);
    set_div(5);
    push(0, 0, 1);
    arm_measure(n); idle(3);
    check(n == 5, "R3", "arm to present, divisor 5", n, 5);
    set_div(0);
    push(0, 0, 1);
    arm_measure(n); idle(3);
    check(n == 1, "R3", "arm to present, divisor 0", n, 1);

    // R2 / R6 / R7: per-scan pacing, continuous, then stop
    wr(3'd2, 8'h04);
    put_entry(1, 0, 2'd0, 4'd2);
    put_entry(0, 1, 2'd1, 4'd5);
    put_entry(0, 0, 2'd3, 4'd7);
    set_div(4);
    wr(3'd1, 8'h05);
    for (int k = 0; k < 2; k++) begin push(0, 0, 2); push(1, 1, 5); push(0, 3, 7); end
    base = hs_cyc.size(); e0 = eos_cnt;
    arm_measure(n);
    check(n == 4, "R3", "first scan start delay", n, 4);
    wait (hs_cnt >= base + 6);
    @(negedge clk);
    wr(3'd2, 8'h02);
    check(!running && !conv_valid, "R8", "stop ends run", {running, conv_valid}, 0);
    idle(20);
    check(hs_cyc.size() == base + 6, "R8", "no conversion after stop", hs_cyc.size() - base, 6);
    check(hs_cyc[base+1] - hs_cyc[base] == 1, "R2", "burst gap B", hs_cyc[base+1] - hs_cyc[base], 1);
    check(hs_cyc[base+2] - hs_cyc[base+1] == 1, "R2", "burst gap C", hs_cyc[base+2] - hs_cyc[base+1], 1);
    check(hs_cyc[base+3] - hs_cyc[base] == 4, "R2", "scan period", hs_cyc[base+3] - hs_cyc[base], 4);
    check(eos_cnt - e0 == 2, "R7", "two passes", eos_cnt - e0, 2);
    check(exp_q.size() == 0, "R6", "wrapped sequence consumed", exp_q.size(), 0);

    // R4: clock select 2, other enables ignored
    wr(3'd2, 8'h04);
    put_entry(1, 1, 2'd2, 4'd12);
    set_div(1);
    wr(3'd1, 8'h02);
    base_en = 4'b1011;
    push(1, 2, 12);
    base = hs_cnt;
    wr(3'd2, 8'h01); idle(20);
    check(running && !conv_valid, "R4", "unselected enables ignored", {running, conv_valid}, 2);
    base_en = 4'b0100; @(negedge clk); base_en = 4'b0000; idle(3);
    check(hs_cnt - base == 1, "R4", "selected enable paces", hs_cnt - base, 1);
    check(!running, "R5", "one-shot done after tick", running, 0);
    base_en = 4'b1111;

    // R11: back-pressure hold
    wr(3'd2, 8'h04);
    wr(3'd1, 8'h01);
    put_entry(0, 0, 2'd1, 4'd11);
    conv_ready = 1'b0;
    base = hs_cnt;
    wr(3'd2, 8'h01); idle(10);
    check(conv_valid && conv_chan == 4'd11 && conv_gain == 2'd1, "R11", "held under back-pressure",
          {conv_valid, conv_gain, conv_chan}, {1'b1, 2'd1, 4'd11});
    push(0, 1, 11);
    conv_ready = 1'b1; idle(3);
    check(hs_cnt - base == 1, "R11", "released after ready", hs_cnt - base, 1);

    // R8: stop while presenting under back-pressure
    wr(3'd1, 8'h05);
    conv_ready = 1'b0;
    wr(3'd2, 8'h01); idle(2);
    check(conv_valid, "R8", "presenting before stop", conv_valid, 1);
    wr(3'd2, 8'h02);
    check(!conv_valid && !running, "R8", "valid drops on stop", {conv_valid, running}, 0);
    conv_ready = 1'b1; idle(2);

    // R9: half-written entry discarded by reset queue
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h80);
    wr(3'd2, 8'h04);
    put_entry(0, 1, 2'd0, 4'd6);
    push(1, 0, 6);
    base = hs_cnt;
    wr(3'd2, 8'h01); idle(4);
    check(hs_cnt - base == 1 && exp_q.size() == 0, "R9", "fresh entry after reset queue", hs_cnt - base, 1);

    // R10: writes beyond DEPTH ignored
    wr(3'd2, 8'h04);
    for (int k = 0; k < DEPTH + 2; k++) put_entry(0, 0, 2'(k % 4), 4'(k));
    for (int k = 0; k < DEPTH; k++) push(0, 2'(k % 4), 4'(k));
    push(0, 0, 0);
    base = hs_cnt;
    for (int k = 0; k < DEPTH + 1; k++) begin wr(3'd2, 8'h01); idle(3); end
    check(hs_cnt - base == DEPTH + 1, "R10", "conversions after full list", hs_cnt - base, DEPTH + 1);
    check(exp_q.size() == 0, "R10", "wrap skips dropped entries", exp_q.size(), 0);

    finish_run();
  end
endmodule